// File: doc/BRIEF.md
# Segmented Quadrature Position Counter

The block counts position from up to three incremental encoder channels. Each channel has its own A, B and Z inputs. One 48-bit position register is divided at run time into one, two or three independent up/down counters, and a 3-bit layout code chooses the division. Every A/B transition is decoded at 4x resolution. A Z pulse counts only when A and B sit at a programmable level. Qualified Z pulses clear the counter of their channel according to a startup referencing rule. A mode input turns the whole register into a plain data word: counting stops and the register port writes and reads the word directly.

The register port has 16-bit words at addresses 0 to 2. Reading address 0 returns the live low word and also captures the full 48-bit register. Reads of addresses 1 and 2 then return words from that captured copy, so a multi-word value always comes from a single instant.

Each channel has a referencing state machine. It starts in REF_ARM0. The transition "first" moves it to REF_ARM1 on the first qualified pulse. The transition "second" moves it to REF_LOCKED on the next qualified pulse. REF_LOCKED is held, with the transition "hold", until the transition "rearm". "rearm" takes it back to REF_ARM0 from any state when the referencing-arm input rises or the layout code changes. In REF_ARM0 and REF_ARM1 a qualified pulse always clears the counter. In REF_LOCKED a pulse clears the counter only when that channel's clear enable is set.

Top module: `segq_counter`

## Requirements
- R1: Counter k takes its count from channel k. Counter 0 sits at bit 0, and each further counter follows directly above the one before. Layout code 000 gives 24 bits. Code 001 gives 24+24 bits and code 010 gives 48 bits. Code 011 gives 16 bits and code 100 gives 32 bits. Code 101 gives 32+16 bits, code 110 gives 16+16 bits and code 111 gives 16+16+16 bits. Register bits that no counter uses are never changed by counting.
- R2: Define the phase of (A,B) as 0 for (0,0), 1 for (1,0), 2 for (1,1) and 3 for (0,1). After the two-flop input synchronizer, a phase step of +1 adds one to the counter and a step of -1 subtracts one. The register reflects the step three clock edges after the input change.
- R3: A step of two phases, where A and B change together, leaves the count unchanged. It sets step_err[k], and the flag stays set until reset.
- R4: Each counter wraps modulo 2 to the power of its width, and the other counters are left untouched.
- R5: The index qualify code q accepts Z as active only when A equals the inverse of q[1] and B equals the inverse of q[0]. So 00 needs A=1,B=1, 01 needs A=1,B=0, 10 needs A=0,B=1 and 11 needs A=0,B=0.
- R6: The first two qualified pulses on a channel clear its counter whatever the clear enables hold. From the third pulse on, counter 0 is cleared only if zclr_en[0] is set and counter 1 only if zclr_en[1] is set. Counter 2 is never cleared after its first two pulses.
- R7: A rising zref_arm restarts the two-pulse sequence on all channels. A change of layout code restarts the sequence and also zeroes the whole register.
- R8: A clear fires once per pulse, on the first cycle in which Z is qualified as active, and in that cycle it overrides a count step.
- R9: While data_mode is 1, no counter counts and no index pulse clears anything. A write to word address a (0 to 2) stores reg_wdata in register bits 16a+15 to 16a.
- R10: A read returns data one edge after reg_rd. Address 0 returns the live bits 15:0 and captures all 48 bits. Addresses 1 and 2 return bits 31:16 and 47:32 of the last capture. Writes are ignored while data_mode is 0.
- R11: After reset the register, reg_rdata and step_err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quad_a | input | 3 | A inputs, one bit per channel |
| quad_b | input | 3 | B inputs, one bit per channel |
| quad_z | input | 3 | Index inputs, one bit per channel |
| layout_code | input | 3 | Counter partition code |
| zqual_code | input | 2 | A/B level at which Z is accepted |
| zclr_en | input | 2 | Index clear enables for counters 0 and 1 |
| zref_arm | input | 1 | Rising edge restarts index referencing |
| data_mode | input | 1 | 1: register is a data word, counting stopped |
| reg_wr | input | 1 | Word write strobe |
| reg_rd | input | 1 | Word read strobe |
| reg_addr | input | 2 | Word address 0 to 2 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| step_err | output | 3 | Sticky illegal-step flags, one per channel |

## Verification
The hardest case to reach is the cycle in which a step and a qualified index arrive together. The bench raises Z first while A/B sit off the qualifying level, then steps A/B onto that level, so qualification and the count step land on the same edge. A pulse that is ignored only becomes visible after the referencing machine has reached its locked state. To get there, the bench first spends two pulses on each channel, with qualify codes swept across all four A/B phases. It then checks that the third and later pulses follow the clear enables, while counter 2 ignores them.

// File: rtl/segq_pkg.sv
package segq_pkg;
    localparam int SEG_WORD_W = 16;
    localparam int SEG_N_CH   = 3;
    localparam int SEG_REG_W  = SEG_WORD_W * SEG_N_CH;
    localparam int SEG_LEN_W  = $clog2(SEG_REG_W + 1);

    typedef enum logic [1:0] {
        REF_ARM0   = 2'd0,
        REF_ARM1   = 2'd1,
        REF_LOCKED = 2'd2
    } ref_state_t;

    // width of counter k for a partition code; 0 means absent
    function automatic logic [SEG_LEN_W-1:0] seg_len(input logic [2:0] code, input int k);
        unique case (code)
            3'b000: return (k == 0) ? SEG_LEN_W'(24) : '0;
            3'b001: return (k < 2)  ? SEG_LEN_W'(24) : '0;
            3'b010: return (k == 0) ? SEG_LEN_W'(48) : '0;
            3'b011: return (k == 0) ? SEG_LEN_W'(16) : '0;
            3'b100: return (k == 0) ? SEG_LEN_W'(32) : '0;
            3'b101: return (k == 0) ? SEG_LEN_W'(32) : ((k == 1) ? SEG_LEN_W'(16) : '0);
            3'b110: return (k < 2)  ? SEG_LEN_W'(16) : '0;
            default: return SEG_LEN_W'(16);
        endcase
    endfunction

    function automatic logic [SEG_LEN_W-1:0] seg_off(input logic [2:0] code, input int k);
        if (k == 0) return '0;
        if (k == 1) return seg_len(code, 0);
        return seg_len(code, 0) + seg_len(code, 1);
    endfunction
endpackage

// File: rtl/segq_sync.sv
module segq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/segq_chan.sv
module segq_chan (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a,
    input  logic       b,
    input  logic       z,
    input  logic [1:0] zqual,
    input  logic       hold,
    output logic       step_up,
    output logic       step_dn,
    output logic       zpulse,
    output logic       err
);
    logic [1:0] ab_q;
    logic       zq_d;
    logic       zq;
    logic [1:0] dph;

    function automatic logic [1:0] phase_of(input logic pa, input logic pb);
        return {pb, pa ^ pb};
    endfunction

    assign dph     = phase_of(a, b) - phase_of(ab_q[1], ab_q[0]);
    assign step_up = (dph == 2'd1);
    assign step_dn = (dph == 2'd3);
    assign zq      = z && (a == ~zqual[1]) && (b == ~zqual[0]);
    assign zpulse  = zq && !zq_d && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ab_q <= 2'b00;
            zq_d <= 1'b0;
            err  <= 1'b0;
        end else begin
            ab_q <= {a, b};
            zq_d <= zq;
            if (dph == 2'd2) err <= 1'b1;
        end
    end

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
endmodule

// File: rtl/segq_ref_fsm.sv
module segq_ref_fsm
    import segq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic pulse,
    input  logic clr_en,
    output logic clr_go
);
    ref_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= REF_ARM0;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (restart) begin
            state_nx = REF_ARM0;
        end else if (pulse) begin
            unique case (state)
                REF_ARM0:   state_nx = REF_ARM1;
                REF_ARM1:   state_nx = REF_LOCKED;
                REF_LOCKED: state_nx = REF_LOCKED;
                default:    state_nx = REF_ARM0;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            REF_ARM0, REF_ARM1: clr_go = pulse;
            REF_LOCKED:         clr_go = pulse && clr_en;
            default:            clr_go = 1'b0;
        endcase
    end

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REF_LOCKED && !restart) |=> (state == REF_LOCKED));
endmodule

// File: rtl/segq_counter.sv
module segq_counter
    import segq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEG_N_CH-1:0]   quad_a,
    input  logic [SEG_N_CH-1:0]   quad_b,
    input  logic [SEG_N_CH-1:0]   quad_z,
    input  logic [2:0]            layout_code,
    input  logic [1:0]            zqual_code,
    input  logic [1:0]            zclr_en,
    input  logic                  zref_arm,
    input  logic                  data_mode,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [1:0]            reg_addr,
    input  logic [SEG_WORD_W-1:0] reg_wdata,
    output logic [SEG_WORD_W-1:0] reg_rdata,
    output logic [SEG_N_CH-1:0]   step_err
);
    localparam int IN_W = 3 * SEG_N_CH;

    logic [SEG_REG_W-1:0]            pos_q, pos_nx;
    logic [SEG_REG_W-1:SEG_WORD_W]   snap_q;
    logic [2:0]                      layout_q;
    logic                            arm_q;
    logic                            restart;
    logic                            layout_chg;
    logic [IN_W-1:0]                 in_s;
    logic [SEG_N_CH-1:0]             a_s, b_s, z_s;
    logic [SEG_N_CH-1:0]             up, dn, zp, clr;
    logic [SEG_N_CH-1:0]             clr_en_v;

    segq_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({quad_z, quad_b, quad_a}),
        .q     (in_s)
    );

    assign a_s        = in_s[SEG_N_CH-1:0];
    assign b_s        = in_s[2*SEG_N_CH-1:SEG_N_CH];
    assign z_s        = in_s[3*SEG_N_CH-1:2*SEG_N_CH];
    assign layout_chg = (layout_code != layout_q);
    assign restart    = layout_chg || (zref_arm && !arm_q);
    assign clr_en_v   = {1'b0, zclr_en};

    for (genvar i = 0; i < SEG_N_CH; i++) begin : g_ch
        segq_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .a       (a_s[i]),
            .b       (b_s[i]),
            .z       (z_s[i]),
            .zqual   (zqual_code),
            .hold    (data_mode),
            .step_up (up[i]),
            .step_dn (dn[i]),
            .zpulse  (zp[i]),
            .err     (step_err[i])
        );
        segq_ref_fsm u_ref (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .pulse   (zp[i]),
            .clr_en  (clr_en_v[i]),
            .clr_go  (clr[i])
        );
    end

    always_comb begin
        logic [SEG_LEN_W-1:0] ln;
        logic [SEG_LEN_W-1:0] of;
        logic [SEG_REG_W-1:0] msk;
        logic [SEG_REG_W-1:0] val;
        ln     = '0;
        of     = '0;
        msk    = '0;
        val    = '0;
        pos_nx = pos_q;
        if (layout_chg) begin
            pos_nx = '0;
        end else if (data_mode) begin
            if (reg_wr) begin
                unique case (reg_addr)
                    2'd0:    pos_nx[0 +: SEG_WORD_W]            = reg_wdata;
                    2'd1:    pos_nx[SEG_WORD_W +: SEG_WORD_W]   = reg_wdata;
                    2'd2:    pos_nx[2*SEG_WORD_W +: SEG_WORD_W] = reg_wdata;
                    default: pos_nx = pos_q;
                endcase
            end
        end else begin
            for (int k = 0; k < SEG_N_CH; k++) begin
                ln = seg_len(layout_q, k);
                of = seg_off(layout_q, k);
                if (ln != '0) begin
                    msk = (ln >= SEG_LEN_W'(SEG_REG_W)) ? '1
                        : ((SEG_REG_W'(1) << ln) - SEG_REG_W'(1));
                    val = (pos_q >> of) & msk;
                    if (clr[k])     val = '0;
                    else if (up[k]) val = val + SEG_REG_W'(1);
                    else if (dn[k]) val = val - SEG_REG_W'(1);
                    pos_nx = (pos_nx & ~(msk << of)) | ((val & msk) << of);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q     <= '0;
            snap_q    <= '0;
            layout_q  <= 3'b000;
            arm_q     <= 1'b0;
            reg_rdata <= '0;
        end else begin
            pos_q    <= pos_nx;
            layout_q <= layout_code;
            arm_q    <= zref_arm;
            if (reg_rd) begin
                unique case (reg_addr)
                    2'd0: begin
                        reg_rdata <= pos_q[SEG_WORD_W-1:0];
                        snap_q    <= pos_q[SEG_REG_W-1:SEG_WORD_W];
                    end
                    2'd1:    reg_rdata <= snap_q[2*SEG_WORD_W-1:SEG_WORD_W];
                    2'd2:    reg_rdata <= snap_q[3*SEG_WORD_W-1:2*SEG_WORD_W];
                    default: reg_rdata <= '0;
                endcase
            end
        end
    end

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_mode && !reg_wr && !layout_chg) |=> $stable(pos_q));

    // R1
    seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_mode && !layout_chg &&
         (layout_q == 3'b000 || layout_q == 3'b011 || layout_q == 3'b100 || layout_q == 3'b110))
        |=> $stable(pos_q[SEG_REG_W-1:2*SEG_WORD_W]));

    // R7
    layout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        layout_chg |=> (pos_q == '0));
endmodule

// File: tb/segq_counter_tb_top.sv
module segq_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  quad_a = '0, quad_b = '0, quad_z = '0;
    logic [2:0]  layout_code = 3'b000;
    logic [1:0]  zqual_code = 2'b00;
    logic [1:0]  zclr_en = 2'b00;
    logic        zref_arm = 1'b0;
    logic        data_mode = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  step_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [47:0] exp_cnt [3];
    int          ph [3];
    int          refc [3];

    always #10 clk = ~clk;

    segq_counter dut_i (
        .clk(clk), .rst_n(rst_n), .quad_a(quad_a), .quad_b(quad_b), .quad_z(quad_z),
        .layout_code(layout_code), .zqual_code(zqual_code), .zclr_en(zclr_en),
        .zref_arm(zref_arm), .data_mode(data_mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step_err(step_err)
    );

    function automatic int blen(input logic [2:0] c, input int k);
        case (c)
            3'b000: return (k == 0) ? 24 : 0;
            3'b001: return (k < 2) ? 24 : 0;
            3'b010: return (k == 0) ? 48 : 0;
            3'b011: return (k == 0) ? 16 : 0;
            3'b100: return (k == 0) ? 32 : 0;
            3'b101: return (k == 0) ? 32 : ((k == 1) ? 16 : 0);
            3'b110: return (k < 2) ? 16 : 0;
            default: return 16;
        endcase
    endfunction

    function automatic logic [47:0] bmask(input int len);
        if (len >= 48) return '1;
        return (48'd1 << len) - 48'd1;
    endfunction

    function automatic logic [47:0] exp_word();
        logic [47:0] w;
        int off;
        w = '0;
        off = 0;
        for (int k = 0; k < 3; k++) begin
            if (blen(layout_code, k) != 0) begin
                w = w | ((exp_cnt[k] & bmask(blen(layout_code, k))) << off);
                off = off + blen(layout_code, k);
            end
        end
        return w;
    endfunction

    function automatic logic pa(input int p); return (p == 1) || (p == 2); endfunction
    function automatic logic pb(input int p); return (p == 2) || (p == 3); endfunction

    function automatic logic qual(input int ch);
        return quad_z[ch] && (pa(ph[ch]) == ~zqual_code[1]) && (pb(ph[ch]) == ~zqual_code[0]);
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic index_event(input int ch);
        logic allow;
        if (data_mode) return;
        allow = (refc[ch] < 2) || (ch < 2 && zclr_en[ch]);
        if (refc[ch] < 2) refc[ch]++;
        if (allow && blen(layout_code, ch) != 0) exp_cnt[ch] = '0;
    endtask

    task automatic step(input int ch, input bit up);
        logic oq;
        logic nq;
        oq = qual(ch);
        ph[ch] = up ? (ph[ch] + 1) % 4 : (ph[ch] + 3) % 4;
        quad_a[ch] = pa(ph[ch]);
        quad_b[ch] = pb(ph[ch]);
        nq = qual(ch);
        if (!data_mode && blen(layout_code, ch) != 0)
            exp_cnt[ch] = (up ? exp_cnt[ch] + 48'd1 : exp_cnt[ch] - 48'd1) & bmask(blen(layout_code, ch));
        if (nq && !oq) index_event(ch);
        repeat (5) @(negedge clk);
    endtask

    task automatic zset(input int ch, input logic v);
        logic oq;
        oq = qual(ch);
        quad_z[ch] = v;
        if (qual(ch) && !oq) index_event(ch);
        repeat (5) @(negedge clk);
    endtask

    task automatic zpulse(input int ch);
        zset(ch, 1'b1);
        zset(ch, 1'b0);
    endtask

    task automatic set_layout(input logic [2:0] c);
        if (c != layout_code) begin
            for (int k = 0; k < 3; k++) begin
                exp_cnt[k] = '0;
                refc[k] = 0;
            end
        end
        layout_code = c;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd1(input logic [1:0] a, output logic [15:0] d);
        reg_rd = 1'b1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_word(output logic [47:0] w);
        logic [15:0] d;
        rd1(2'd0, d); w[15:0] = d;
        rd1(2'd1, d); w[31:16] = d;
        rd1(2'd2, d); w[47:32] = d;
    endtask

    task automatic wr1(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] w;
        logic [15:0] d;
        for (int k = 0; k < 3; k++) begin
            exp_cnt[k] = '0;
            ph[k] = 0;
            refc[k] = 0;
        end
        repeat (3) @(negedge clk);
        check("R11 rdata after reset", {32'd0, reg_rdata}, 48'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        read_word(w);
        check("R11 register after reset", w, 48'd0);
        check("R11 step_err after reset", {45'd0, step_err}, 48'd0);

        // R1 R2 R4 R7: sweep every layout, count up then past zero
        for (int l = 0; l < 8; l++) begin
            set_layout(3'(l));
            read_word(w);
            check("R7 layout change zeroes", w, exp_word());
            for (int k = 0; k < 3; k++) begin
                repeat (5 + k) step(k, 1'b1);
                read_word(w);
                check("R2 count up", w, exp_word());
                repeat (7 + k) step(k, 1'b0);
                read_word(w);
                check("R4 wrap below zero / R1 layout", w, exp_word());
            end
        end

        // R5 R6: qualify code sweep over all phases, clears disabled
        set_layout(3'b101);
        for (int q = 0; q < 4; q++) begin
            zqual_code = 2'(q);
            for (int p = 0; p < 4; p++) begin
                step(0, 1'b1);
                step(0, 1'b1);
                zpulse(0);
                zpulse(1);
                read_word(w);
                check("R5 qualify / R6 first two pulses", w, exp_word());
            end
        end
        zclr_en = 2'b11;
        zqual_code = 2'b00;
        for (int p = 0; p < 4; p++) begin
            step(0, 1'b1);
            step(1, 1'b1);
            step(1, 1'b1);
            zpulse(0);
            zpulse(1);
            read_word(w);
            check("R6 enabled clear after lock", w, exp_word());
        end

        // R6: counter 2 has no enable after its first two pulses
        set_layout(3'b111);
        for (int n = 0; n < 3; n++) begin
            step(2, 1'b1);
            step(2, 1'b1);
            zqual_code = {~pa(ph[2]), ~pb(ph[2])};
            zpulse(2);
            read_word(w);
            check("R6 counter 2 pulse", w, exp_word());
        end
        check("R6 counter 2 kept on third pulse", exp_cnt[2], 48'd2);

        // R7: rising arm input restarts referencing
        zclr_en = 2'b00;
        for (int n = 0; n < 2; n++) begin
            zqual_code = {~pa(ph[1]), ~pb(ph[1])};
            zpulse(1);
        end
        repeat (3) step(1, 1'b1);
        zqual_code = {~pa(ph[1]), ~pb(ph[1])};
        zpulse(1);
        read_word(w);
        check("R6 locked pulse ignored", w, exp_word());
        zref_arm = 1'b1;
        for (int k = 0; k < 3; k++) refc[k] = 0;
        repeat (3) @(negedge clk);
        zpulse(1);
        read_word(w);
        check("R7 arm restarts referencing", w, exp_word());
        check("R7 counter 1 cleared", exp_cnt[1], 48'd0);

        // R8: step lands on qualification edge
        set_layout(3'b010);
        zqual_code = 2'b00;
        while (ph[0] != 1) step(0, 1'b1);
        step(0, 1'b0);
        step(0, 1'b1);
        zset(0, 1'b1);
        step(0, 1'b1);
        read_word(w);
        check("R8 clear overrides step", w, 48'd0);
        step(0, 1'b1);
        read_word(w);
        check("R8 one clear per pulse", w, 48'd1);
        zset(0, 1'b0);

        // R9: data mode
        data_mode = 1'b1;
        repeat (2) @(negedge clk);
        wr1(2'd0, 16'hA5C3);
        wr1(2'd1, 16'h0F1E);
        wr1(2'd2, 16'h7B29);
        read_word(w);
        check("R9 data word write", w, 48'h7B29_0F1E_A5C3);
        step(0, 1'b1);
        zpulse(0);
        read_word(w);
        check("R9 no count or clear in data mode", w, 48'h7B29_0F1E_A5C3);
        data_mode = 1'b0;
        exp_cnt[0] = 48'h7B29_0F1E_A5C3;
        repeat (2) @(negedge clk);
        wr1(2'd0, 16'h1234);
        read_word(w);
        check("R10 write ignored in count mode", w, exp_word());

        // R10: snapshot coherence
        set_layout(3'b111);
        step(1, 1'b1);
        step(1, 1'b1);
        rd1(2'd0, d);
        step(1, 1'b1);
        rd1(2'd1, d);
        check("R10 snapshot word", {32'd0, d}, 48'd2);
        read_word(w);
        check("R10 new capture", w, exp_word());

        // R3: illegal two-phase jump
        read_word(w);
        ph[1] = (ph[1] + 2) % 4;
        quad_a[1] = pa(ph[1]);
        quad_b[1] = pb(ph[1]);
        repeat (5) @(negedge clk);
        check("R3 error flag set", {45'd0, step_err}, 48'd2);
        check("R3 count unchanged", w, exp_word());
        step(1, 1'b1);
        read_word(w);
        check("R3 counting resumes", w, exp_word());
        check("R3 error flag sticky", {45'd0, step_err}, 48'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule